// File: doc/BRIEF.md
# Double-Latched Programmable Down Divider

This block divides a fast input clock, normally the output of an RF prescaler, by a programmable 15-bit ratio N. A down counter runs from N-1 to zero. On each terminal count it produces a single-cycle output pulse and reloads. A divide-by-two copy of that pulse train is also provided so that the divided frequency can be routed to a test output.

A ratio comes from a slower bus-side clock domain. A write stores the value in a holding register in that domain and flips a toggle flag. The flag is synchronized into the divider domain and marks a load as pending. The pending value moves into the working register only at the divider's own terminal count. A count already in progress therefore always finishes with the ratio it started with, however the write is timed against the divider.

Ratios below the smallest usable value are raised to that value when written. After reset the divider runs at a default ratio of 256.

Top module: `dual_latch_divider`

## Requirements
- R1: While rst_ni is low, fdiv_o and fby2_o are 0. The working ratio after reset is 256, so the first full output period after reset is 256 cycles of clk_i.
- R2: fdiv_o is high for exactly one clk_i cycle. It is asserted once every N clk_i cycles, where N is the working ratio.
- R3: The ratio is the unsigned binary value of ratio_i, with ratio_i[14] as the most significant bit, giving 32767 at most. A ratio of 32767 gives a 32767-cycle period.
- R4: A written value below 17 (including 0) is stored as 17. Values of 17 and above are stored unchanged.
- R5: The working ratio changes only at a terminal count. The output period in progress when a write arrives completes with the previous ratio.
- R6: A write that reaches the divider domain before the current period ends sets the length of the next period. When several writes land within one period, the last one is used.
- R7: With no new write, the working ratio persists unchanged from period to period.
- R8: fby2_o starts at 0 and toggles in the same cycle as each fdiv_o pulse, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock (prescaled RF) |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| bus_clk_i | input | 1 | Bus-side clock for ratio writes |
| ratio_wr_i | input | 1 | Write strobe, bus_clk_i domain |
| ratio_i | input | 15 | Ratio value, bus_clk_i domain |
| fdiv_o | output | 1 | One-cycle pulse every N input cycles |
| fby2_o | output | 1 | fdiv_o divided by two |

## Verification
On every cycle, the assertions check several properties. The output pulse never lasts two cycles, and fby2_o changes exactly when a pulse occurs. The working ratio never falls below 17, stays frozen between terminal counts, and the counter never reaches the working ratio. Other behaviour can only be shown by the bench's scenarios, which measure the spacing between consecutive pulses. These include the clamp of small written values, the default ratio after reset, and the rule that a write made mid-period leaves the current period alone and sets the next one. They also cover the last-write-wins case and a ratio persisting with no write.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int unsigned RATIO_W     = 15;
  localparam int unsigned MIN_RATIO   = 17;
  localparam int unsigned RESET_RATIO = 256;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic logic [RATIO_W-1:0] clamp_ratio(input logic [RATIO_W-1:0] r);
    if (r < RATIO_W'(MIN_RATIO)) return RATIO_W'(MIN_RATIO);
    return r;
  endfunction
endpackage

// File: rtl/ratio_hold.sv
// Bus-domain holding register with toggle flag per write.
module ratio_hold #(
  parameter int unsigned W = div_pkg::RATIO_W
) (
  input  logic         bus_clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] ratio_i,
  output logic [W-1:0] held_o,
  output logic         flag_o
);
  logic [W-1:0] held_q;
  logic         flag_q;

  always_ff @(posedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= W'(div_pkg::RESET_RATIO);
      flag_q <= 1'b0;
    end else if (wr_i) begin
      held_q <= div_pkg::clamp_ratio(ratio_i);
      flag_q <= ~flag_q;
    end
  end

  assign held_o = held_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/flag_sync.sv
// Synchronizes a toggle flag and emits a one-cycle pulse per toggle.
module flag_sync #(
  parameter int unsigned STAGES = div_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= flag_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign pulse_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/ratio_work.sv
// Working register: takes the held ratio only at terminal count.
module ratio_work #(
  parameter int unsigned W = div_pkg::RATIO_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_req_i,
  input  logic         tc_i,
  input  logic [W-1:0] held_i,
  output logic [W-1:0] work_o,
  output logic [W-1:0] next_o
);
  logic [W-1:0] work_q;
  logic         pend_q;
  logic         take;

  // held_i is quasi-static once the request has been synchronized
  assign take   = tc_i && (pend_q || load_req_i);
  assign next_o = take ? held_i : work_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= W'(div_pkg::RESET_RATIO);
      pend_q <= 1'b0;
    end else begin
      if (tc_i) work_q <= next_o;
      if (take)            pend_q <= 1'b0;
      else if (load_req_i) pend_q <= 1'b1;
    end
  end

  assign work_o = work_q;
endmodule

// File: rtl/down_counter.sv
module down_counter #(
  parameter int unsigned W = div_pkg::RATIO_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;

  assign tc_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= W'(div_pkg::RESET_RATIO - 1);
    else if (tc_o) cnt_q <= reload_i - W'(1);
    else           cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dual_latch_divider.sv
module dual_latch_divider #(
  parameter int unsigned RATIO_W     = div_pkg::RATIO_W,
  parameter int unsigned SYNC_STAGES = div_pkg::SYNC_STAGES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_clk_i,
  input  logic               ratio_wr_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               fdiv_o,
  output logic               fby2_o
);
  logic [RATIO_W-1:0] held_ratio;
  logic               wr_flag;
  logic               load_req;
  logic               term_cnt;
  logic [RATIO_W-1:0] work_ratio;
  logic [RATIO_W-1:0] next_ratio;
  logic [RATIO_W-1:0] cnt_val;
  logic               fdiv_q;
  logic               fby2_q;

  ratio_hold #(.W(RATIO_W)) u_hold (
    .bus_clk_i (bus_clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ratio_wr_i),
    .ratio_i   (ratio_i),
    .held_o    (held_ratio),
    .flag_o    (wr_flag)
  );

  flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flag_i  (wr_flag),
    .pulse_o (load_req)
  );

  ratio_work #(.W(RATIO_W)) u_work (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_req_i (load_req),
    .tc_i       (term_cnt),
    .held_i     (held_ratio),
    .work_o     (work_ratio),
    .next_o     (next_ratio)
  );

  down_counter #(.W(RATIO_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (next_ratio),
    .cnt_o    (cnt_val),
    .tc_o     (term_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fdiv_q <= 1'b0;
      fby2_q <= 1'b0;
    end else begin
      fdiv_q <= term_cnt;
      if (term_cnt) fby2_q <= ~fby2_q;
    end
  end

  assign fdiv_o = fdiv_q;
  assign fby2_o = fby2_q;
endmodule

// File: rtl/dual_latch_divider_chk.sv
module dual_latch_divider_chk #(
  parameter int unsigned W = div_pkg::RATIO_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         fdiv_o,
  input logic         fby2_o,
  input logic         term_cnt,
  input logic [W-1:0] work_ratio,
  input logic [W-1:0] cnt_val
);
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdiv_o |=> !fdiv_o); // R2
  AST_CNT_BELOW_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_val < work_ratio); // R2
  AST_RATIO_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    work_ratio >= W'(div_pkg::MIN_RATIO)); // R4
  AST_RATIO_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !term_cnt |=> $stable(work_ratio)); // R5
  AST_FBY2_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdiv_o |-> (fby2_o != $past(fby2_o))); // R8
  AST_FBY2_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fdiv_o |-> $stable(fby2_o)); // R8
endmodule

bind dual_latch_divider dual_latch_divider_chk #(.W(RATIO_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fdiv_o     (fdiv_o),
  .fby2_o     (fby2_o),
  .term_cnt   (term_cnt),
  .work_ratio (work_ratio),
  .cnt_val    (cnt_val)
);

// File: tb/tb_dual_latch_divider.sv
module tb_dual_latch_divider;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_PERIOD = 30;
  localparam int WDOG       = 200000;

  logic        clk_i = 1'b0;
  logic        bus_clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ratio_wr_i = 1'b0;
  logic [14:0] ratio_i = '0;
  logic        fdiv_o;
  logic        fby2_o;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  int cyc = 0;
  int last_pulse = 0;
  int npulse = 0;
  bit done = 1'b0;
  event pulse_ev;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always #(BUS_PERIOD/2) bus_clk_i = ~bus_clk_i;

  dual_latch_divider dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_clk_i  (bus_clk_i),
    .ratio_wr_i (ratio_wr_i),
    .ratio_i    (ratio_i),
    .fdiv_o     (fdiv_o),
    .fby2_o     (fby2_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int r);
    return (r < 17) ? 17 : r;
  endfunction

  task automatic bus_write(input int r);
    @(negedge bus_clk_i);
    ratio_i    = 15'(r);
    ratio_wr_i = 1'b1;
    @(negedge bus_clk_i);
    ratio_wr_i = 1'b0;
  endtask

  // monitor: measures spacing between pulses against the queue
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      cyc++;
      if (fdiv_o) begin
        npulse++;
        check("R8 fby2 level", int'(fby2_o), npulse % 2);
        if (npulse > 1) begin
          if (exp_q.size() == 0) check("R2 unexpected pulse", cyc - last_pulse, -1);
          else check("R2/R5/R6 period", cyc - last_pulse, exp_q.pop_front());
        end
        last_pulse = cyc;
        -> pulse_ev;
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seq[$];
    int cur;
    repeat (3) @(negedge clk_i);
    check("R1 fdiv in reset", int'(fdiv_o), 0);
    check("R1 fby2 in reset", int'(fby2_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: interval pulse1->pulse2 uses reset ratio 256
    exp_q.push_back(256);
    cur = 256;
    // -1: no write (R7); -2: double write 60 then 33 (R6)
    // 5 and 0 clamp (R4); 32767 max (R3)
    seq = '{40, 5, 17, 18, 0, 100, -2, -1, 32767, 20};
    foreach (seq[i]) begin
      @(pulse_ev);
      if (seq[i] == -1) begin
        exp_q.push_back(cur);
      end else if (seq[i] == -2) begin
        bus_write(60);
        bus_write(33);
        cur = 33;
        exp_q.push_back(cur);
      end else begin
        bus_write(seq[i]);
        cur = eff(seq[i]);
        exp_q.push_back(cur);
      end
    end
    @(pulse_ev);
    @(pulse_ev);
    @(negedge clk_i);
    check("R2 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule